// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers reset requests from several internal sources and turns the first one it accepts into a single internal system reset. The reset is held for a fixed number of clock cycles. The sources are:

- a software write,
- a flash access violation,
- a watchdog timeout,
- an analog comparator trip,
- a real-time-clock event, which is either an oscillator failure or an alarm match.

A small status/enable register records which source caused the most recent reset. Writes to the same register arm the comparator and real-time-clock sources, and a write can also force a software reset. One read bit is shared between the comparator and the watchdog.

The low-power state changes which sources can fire:

- The watchdog is masked while the chip is in low power. Its enable state comes back unchanged when the chip wakes.
- The comparator can fire in low power only if it is also armed as a wake-up source.
- The real-time clock can fire in low power without any condition.

Every accepted reset re-enables the watchdog and restarts its divide-by-12 tick. This block never drives the external reset pin.

Top module: `sysrst_ctrl`

## Requirements
- R1: When a request is accepted at a clock edge, `sys_rst_o` is high for exactly 8 consecutive cycles starting right after that edge.
- R2: A write with `reg_wdata_i[4]`=1 forces a reset. `reg_rdata_o[4]` reads 1 after a software reset and 0 after any other reset.
- R3: A write sets or clears the comparator arm from `reg_wdata_i[5]`. When armed, `cmp_lt_i`=1 (non-inverting input below inverting input) causes a reset, after which `reg_rdata_o[5]` reads 1.
- R4: `flash_viol_i`=1 causes a reset. `reg_rdata_o[6]` reads 1 after a flash reset and 0 otherwise.
- R5: A write sets or clears the real-time-clock arm from `reg_wdata_i[7]`. When armed, either `rtc_osc_fail_i` or `rtc_alarm_i` causes a reset, after which `reg_rdata_o[7]` reads 1.
- R6: `wdt_expire_i` while the watchdog is active causes a reset, after which `reg_rdata_o[5]` reads 1.
- R7: While `lowpwr_i`=1, the watchdog is inactive and its timeouts are ignored, and the comparator fires only if `cmp_wake_en_i`=1. The real-time clock still fires. When `lowpwr_i` returns to 0, the watchdog's earlier enable state is restored.
- R8: Requests in the same cycle are resolved in priority order, highest first: software, flash, watchdog, comparator, real-time clock. At most one of `reg_rdata_o[7:4]` is ever 1, and `reg_rdata_o[3:0]` is always 0.
- R9: A `wdt_off_i` pulse disables the watchdog. Every accepted reset re-enables it and restarts its divider. While active, the watchdog pulses `wdt_tick_o` once every 12 cycles.
- R10: While `sys_rst_o` is high, all requests, register writes and `wdt_off_i` are ignored.
- R11: After `rst_ni` is released, `sys_rst_o`=0, `reg_rdata_o`=0, both sources are unarmed, and the watchdog is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| reg_we_i | input | 1 | Status/enable register write strobe |
| reg_wdata_i | input | 8 | Write data: bit 4 forces a software reset, bit 5 arms the comparator, bit 7 arms the real-time clock |
| reg_rdata_o | output | 8 | Reset cause: bit 7 real-time clock, bit 6 flash, bit 5 comparator or watchdog, bit 4 software |
| cmp_lt_i | input | 1 | Comparator output: non-inverting input below inverting input |
| cmp_wake_en_i | input | 1 | Comparator armed as a wake-up source |
| wdt_expire_i | input | 1 | Watchdog counter timeout |
| wdt_off_i | input | 1 | Watchdog disable pulse |
| flash_viol_i | input | 1 | Illegal flash access detected |
| rtc_osc_fail_i | input | 1 | Real-time-clock oscillator failure |
| rtc_alarm_i | input | 1 | Real-time-clock alarm match |
| lowpwr_i | input | 1 | Chip is in suspend or sleep |
| sys_rst_o | output | 1 | Internal system reset, active high |
| wdt_active_o | output | 1 | Watchdog enabled and not masked by low power |
| wdt_tick_o | output | 1 | Watchdog clock-enable pulse, once every 12 cycles |

## Verification
The assertions assume that every request input is synchronous to `clk_i` and stable around the rising edge. They also assume that `lowpwr_i` and `cmp_wake_en_i` change only between edges. The stimulus drives every input on the falling edge.

Request pulses are one cycle wide, except where a scenario deliberately holds a request across a reset window to show that it is ignored.

Simultaneous requests are applied only in cycles where `sys_rst_o` is low, so each one reaches the priority logic.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int unsigned NUM_SRC = 5;
  // request index == priority rank, 0 highest
  localparam int unsigned SRC_SW    = 0;
  localparam int unsigned SRC_FLASH = 1;
  localparam int unsigned SRC_WDT   = 2;
  localparam int unsigned SRC_CMP   = 3;
  localparam int unsigned SRC_RTC   = 4;
  // register bit positions
  localparam int unsigned BIT_SW    = 4;
  localparam int unsigned BIT_SHARE = 5;
  localparam int unsigned BIT_FLASH = 6;
  localparam int unsigned BIT_RTC   = 7;

  typedef struct packed {
    logic rtc;
    logic flash;
    logic share;
    logic sw;
  } cause_t;
endpackage

// File: rtl/sysrst_arb.sv
module sysrst_arb #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/sysrst_hold.sv
module sysrst_hold #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= HOLD_V;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sysrst_wdt_ctl.sv
module sysrst_wdt_ctl #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic off_i,
  input  logic lowpwr_i,
  output logic active_o,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);
  logic          en_q;
  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b1;
    else if (start_i)  en_q <= 1'b1;
    else if (off_i)    en_q <= 1'b0;
  end

  // enable kept through low power, only masked
  assign active_o = en_q & ~lowpwr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (start_i)  div_q <= '0;
    else if (active_o) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
  end
  assign tick_o = active_o & (div_q == LAST);
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
  import sysrst_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 8,
  parameter int unsigned WDT_DIV  = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       cmp_lt_i,
  input  logic       cmp_wake_en_i,
  input  logic       wdt_expire_i,
  input  logic       wdt_off_i,
  input  logic       flash_viol_i,
  input  logic       rtc_osc_fail_i,
  input  logic       rtc_alarm_i,
  input  logic       lowpwr_i,
  output logic       sys_rst_o,
  output logic       wdt_active_o,
  output logic       wdt_tick_o
);
  logic               busy, idle, accept;
  logic               cmp_arm_q, rtc_arm_q;
  logic [NUM_SRC-1:0] req, gnt;
  cause_t             cause_q;

  assign idle = ~busy;

  always_comb begin
    req            = '0;
    req[SRC_SW]    = reg_we_i & reg_wdata_i[BIT_SW];
    req[SRC_FLASH] = flash_viol_i;
    req[SRC_WDT]   = wdt_expire_i & wdt_active_o;
    req[SRC_CMP]   = cmp_arm_q & cmp_lt_i & (~lowpwr_i | cmp_wake_en_i);
    req[SRC_RTC]   = rtc_arm_q & (rtc_osc_fail_i | rtc_alarm_i);
    if (!idle) req = '0;
  end

  sysrst_arb #(.N(NUM_SRC)) u_arb (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (accept)
  );

  sysrst_hold #(.HOLD(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .busy_o (busy)
  );

  sysrst_wdt_ctl #(.DIV(WDT_DIV)) u_wdt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .off_i    (wdt_off_i & idle),
    .lowpwr_i (lowpwr_i),
    .active_o (wdt_active_o),
    .tick_o   (wdt_tick_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_arm_q <= 1'b0;
      rtc_arm_q <= 1'b0;
    end else if (idle && reg_we_i) begin
      cmp_arm_q <= reg_wdata_i[BIT_SHARE];
      rtc_arm_q <= reg_wdata_i[BIT_RTC];
    end
  end

  // cause latched at assertion; comparator and watchdog share one bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (accept) begin
      cause_q.sw    <= gnt[SRC_SW];
      cause_q.flash <= gnt[SRC_FLASH];
      cause_q.share <= gnt[SRC_WDT] | gnt[SRC_CMP];
      cause_q.rtc   <= gnt[SRC_RTC];
    end
  end

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[BIT_SW]    = cause_q.sw;
    reg_rdata_o[BIT_SHARE] = cause_q.share;
    reg_rdata_o[BIT_FLASH] = cause_q.flash;
    reg_rdata_o[BIT_RTC]   = cause_q.rtc;
  end

  assign sys_rst_o = busy;
endmodule

// File: rtl/sysrst_ctrl_chk.sv
module sysrst_ctrl_chk #(
  parameter int unsigned HOLD_CYC = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_rst_o,
  input logic [7:0] reg_rdata_o,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic       flash_viol_i,
  input logic       lowpwr_i,
  input logic       wdt_active_o,
  input logic       wdt_tick_o
);
  int unsigned run_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_len <= 0;
    else if (sys_rst_o) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  assert_hold_min_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && run_len < HOLD_CYC - 1) |=> sys_rst_o);
  assert_hold_max_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> run_len < HOLD_CYC);
  assert_cause_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_rdata_o[7:4]) && reg_rdata_o[3:0] == 4'h0);
  assert_flash_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && $past(flash_viol_i && !(reg_we_i && reg_wdata_i[4])))
      |-> reg_rdata_o[6]);
  assert_cause_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && $past(sys_rst_o)) |-> $stable(reg_rdata_o));
  assert_lp_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_i |-> !wdt_active_o);
  assert_wdt_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && !lowpwr_i) |-> wdt_active_o);
  assert_tick_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tick_o |-> wdt_active_o);
endmodule

bind sysrst_ctrl sysrst_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_o    (sys_rst_o),
  .reg_rdata_o  (reg_rdata_o),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .flash_viol_i (flash_viol_i),
  .lowpwr_i     (lowpwr_i),
  .wdt_active_o (wdt_active_o),
  .wdt_tick_o   (wdt_tick_o)
);

// File: tb/sysrst_ctrl_tb.sv
`timescale 1ns/1ps
module sysrst_ctrl_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 0, cmp_lt = 0, cmp_wake = 0, wdt_exp = 0, wdt_off = 0;
  logic flash = 0, osc_fail = 0, alarm = 0, lp = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic sys_rst, wdt_act, wdt_tick;
  int n_chk = 0, n_fail = 0;
  string cur_tag = "R11";
  bit done = 0;

  always #2 clk = ~clk;

  sysrst_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cmp_lt_i(cmp_lt), .cmp_wake_en_i(cmp_wake),
    .wdt_expire_i(wdt_exp), .wdt_off_i(wdt_off), .flash_viol_i(flash),
    .rtc_osc_fail_i(osc_fail), .rtc_alarm_i(alarm), .lowpwr_i(lp),
    .sys_rst_o(sys_rst), .wdt_active_o(wdt_act), .wdt_tick_o(wdt_tick)
  );

  // behavioural reference model
  int m_cnt = 0, m_div = 0;
  bit m_cmp_en = 0, m_rtc_en = 0, m_wdt_en = 1;
  logic [7:0] m_rd = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_div = 0; m_cmp_en = 0; m_rtc_en = 0; m_wdt_en = 1; m_rd = 0;
    end else begin
      bit act, acc;
      act = m_wdt_en && !lp;
      acc = 0;
      if (m_cnt > 0) m_cnt--;
      else begin
        if (reg_we && wdata[4])                           begin acc = 1; m_rd = 8'h10; end
        else if (flash)                                   begin acc = 1; m_rd = 8'h40; end
        else if (wdt_exp && act)                          begin acc = 1; m_rd = 8'h20; end
        else if (m_cmp_en && cmp_lt && (!lp || cmp_wake)) begin acc = 1; m_rd = 8'h20; end
        else if (m_rtc_en && (osc_fail || alarm))         begin acc = 1; m_rd = 8'h80; end
        if (reg_we) begin m_cmp_en = wdata[5]; m_rtc_en = wdata[7]; end
        if (acc) begin m_cnt = 8; m_wdt_en = 1; end
        else if (wdt_off) m_wdt_en = 0;
      end
      if (acc) m_div = 0;
      else if (act) m_div = (m_div == 11) ? 0 : m_div + 1;
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_ni && !done) begin
      bit e_act;
      e_act = m_wdt_en && !lp;
      chk({cur_tag, " model"}, {sys_rst, wdt_tick, wdt_act, rdata},
          {m_cnt != 0, e_act && m_div == 11, e_act, m_rd});
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    reg_we = 0; wdata = 0; flash = 0; wdt_exp = 0; wdt_off = 0;
    osc_fail = 0; alarm = 0;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_we = 1; wdata = d;
    @(negedge clk); clr();
  endtask

  task automatic wait_idle();
    while (sys_rst) @(negedge clk);
    cyc(1);
  endtask

  task automatic measure_hold(string tag);
    int len = 0;
    #1;
    while (sys_rst) begin len++; @(negedge clk); #1; end
    chk(tag, len, 8);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ticks;
    cyc(3); rst_ni = 1; cyc(1); #1;
    chk("R11 sys_rst", sys_rst, 0);
    chk("R11 rdata", rdata, 0);
    chk("R11 wdt_active", wdt_act, 1);

    cur_tag = "R2";
    @(negedge clk); reg_we = 1; wdata = 8'h10;
    @(negedge clk); clr(); #1;
    chk("R2 sw cause", rdata, 8'h10);
    measure_hold("R1 hold length");
    wait_idle();

    cur_tag = "R4";
    @(negedge clk); flash = 1;
    @(negedge clk); clr(); #1;
    chk("R4 flash cause", rdata, 8'h40);
    chk("R2 sw bit cleared", rdata[4], 0);
    wait_idle();

    cur_tag = "R3";
    wr(8'h20); #1;
    chk("R3 arm no reset", sys_rst, 0);
    @(negedge clk); cmp_lt = 1;
    @(negedge clk); cmp_lt = 0; #1;
    chk("R3 cmp cause", {sys_rst, rdata}, {1'b1, 8'h20});
    wait_idle();

    cur_tag = "R5";
    wr(8'h80);
    @(negedge clk); osc_fail = 1;
    @(negedge clk); clr(); #1;
    chk("R5 osc fail cause", {sys_rst, rdata}, {1'b1, 8'h80});
    wait_idle();
    @(negedge clk); alarm = 1;
    @(negedge clk); clr(); #1;
    chk("R5 alarm cause", {sys_rst, rdata}, {1'b1, 8'h80});
    wait_idle();

    cur_tag = "R6";
    @(negedge clk); wdt_exp = 1;
    @(negedge clk); clr(); #1;
    chk("R6 wdt cause", {sys_rst, rdata}, {1'b1, 8'h20});
    wait_idle();

    cur_tag = "R7";
    @(negedge clk); lp = 1; #1;
    chk("R7 wdt masked", wdt_act, 0);
    wr(8'hA0);
    @(negedge clk); wdt_exp = 1;
    @(negedge clk); clr(); #1;
    chk("R7 wdt ignored in lp", sys_rst, 0);
    @(negedge clk); cmp_lt = 1; cmp_wake = 0;
    cyc(3); cmp_lt = 0; #1;
    chk("R7 cmp blocked no wake", {sys_rst, rdata}, {1'b0, 8'h20});
    @(negedge clk); alarm = 1;
    @(negedge clk); clr(); #1;
    chk("R7 rtc active in lp", {sys_rst, rdata}, {1'b1, 8'h80});
    wait_idle();
    @(negedge clk); cmp_wake = 1; cmp_lt = 1;
    @(negedge clk); cmp_lt = 0; #1;
    chk("R7 cmp with wake", {sys_rst, rdata}, {1'b1, 8'h20});
    wait_idle();
    @(negedge clk); lp = 0; cmp_wake = 0; #1;
    chk("R7 wdt restored", wdt_act, 1);

    cur_tag = "R8";
    @(negedge clk); reg_we = 1; wdata = 8'hB0; flash = 1; wdt_exp = 1;
    cmp_lt = 1; osc_fail = 1;
    @(negedge clk); clr(); cmp_lt = 0; #1;
    chk("R8 sw wins", rdata, 8'h10);
    wait_idle();
    @(negedge clk); flash = 1; wdt_exp = 1; cmp_lt = 1; alarm = 1;
    @(negedge clk); clr(); cmp_lt = 0; #1;
    chk("R8 flash wins", rdata, 8'h40);
    wait_idle();
    @(negedge clk); cmp_lt = 1; alarm = 1;
    @(negedge clk); clr(); cmp_lt = 0; #1;
    chk("R8 cmp over rtc", rdata, 8'h20);
    wait_idle();

    cur_tag = "R9";
    @(negedge clk); wdt_off = 1;
    @(negedge clk); clr(); #1;
    chk("R9 wdt disabled", wdt_act, 0);
    @(negedge clk); wdt_exp = 1;
    @(negedge clk); clr(); #1;
    chk("R9 disabled wdt no reset", sys_rst, 0);
    ticks = 0;
    repeat (24) begin @(negedge clk); #1; ticks += wdt_tick; end
    chk("R9 no ticks when off", ticks, 0);
    @(negedge clk); flash = 1;
    @(negedge clk); clr(); #1;
    chk("R9 rearmed by reset", wdt_act, 1);
    wait_idle();
    ticks = 0;
    repeat (48) begin @(negedge clk); #1; ticks += wdt_tick; end
    chk("R9 tick every 12", ticks, 4);

    cur_tag = "R10";
    wr(8'h00);
    @(negedge clk); flash = 1;
    @(negedge clk); clr(); reg_we = 1; wdata = 8'hB0; wdt_off = 1; alarm = 1;
    @(negedge clk); clr(); #1;
    chk("R10 cause kept", rdata, 8'h40);
    chk("R10 wdt_off ignored", wdt_act, 1);
    wait_idle();
    @(negedge clk); alarm = 1;
    @(negedge clk); clr(); #1;
    chk("R10 write during hold ignored", sys_rst, 0);
    @(negedge clk); flash = 1;
    @(negedge clk); #1;
    measure_hold("R10 held request no extension");
    clr();
    wait_idle();

    cyc(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule